// File: doc/BRIEF.md
# Source Throttling Interval Controller

This block keeps the slowdown that cores suffer in a shared memory system within bounds by acting at the cores themselves. It does not arbitrate inside the shared resources. Once per interval of a fixed number of cycles, it takes the following inputs:

- an estimated slowdown for every core, as an 8.8 fixed-point value;
- a software weight for every core, as a 4.4 fixed-point value;
- a matrix of interference counts. Each entry gives the interference that one core caused another during the interval.

From these it decides whether the system is unfair. If it is, it lowers the allowance of one core, the one that hurt the worst-off core most. In the same step it raises the allowance of the worst-off core.

Each core owns an allowance level in the range 0 to 7. Level 7 means unthrottled. The level drives two outputs:

- a limit on outstanding misses, taken from a fixed table;
- an injection gap, which is the number of idle cycles the core must leave between requests.

A two-bit mode input chooses the fairness test:

| Mode | Test |
|------|------|
| 0 | Ratio of the largest to the smallest weighted slowdown |
| 1 | Largest weighted slowdown alone |
| 2 | Each core against its own target |
| 3 | Throttling is frozen |

The slowdown estimates and the interference counts come from outside the block.

Top module: `src_throttle_ctl`

## Requirements
- R1: After reset every level is 7, every miss limit is 24 and every injection gap is 0.
- R2: An evaluation happens once every INTERVAL cycles. Its result appears in the cycle after the evaluation edge, together with a one-cycle pulse on `eval_strobe_o`. Levels change at no other time.
- R3: The weighted slowdown of core i is (slowdown_i × weight_i) >> 4. The slowest core is the one with the largest weighted slowdown. Ties go to the lower index.
- R4: The interferer is the core j ≠ slowest with the largest count in row `slowest` of the interference matrix. Entry (victim v, source s) sits at bits [(v·N+s)·IC_W +: IC_W]. Ties go to the lower index.
- R5: When unfairness is detected, the interferer's level drops by one and the slowest core's level rises by one. Both saturate, at 0 and at 7 respectively. All other levels are unchanged.
- R6: When unfairness is not detected, all levels hold for the next interval.
- R7: Mode 0 detects unfairness when max·256 > sys_target·min, with all three values in 8.8. Equality does not trigger.
- R8: Mode 1 detects unfairness when the largest weighted slowdown is strictly above sys_target.
- R9: Mode 2 detects unfairness when any core's weighted slowdown is strictly above that core's own target.
- R10: Mode 3 never detects unfairness, so levels stay frozen whatever the inputs.
- R11: The miss limit for levels 0 to 7 is 1, 2, 3, 4, 8, 12, 16, 24. The injection gap is 7 minus the level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Fairness test: 0 ratio, 1 max, 2 per-core, 3 frozen |
| sys_tgt_i | input | SD_W | System target, 8.8 (ratio in mode 0, max slowdown in mode 1) |
| core_tgt_i | input | NCORES·SD_W | Per-core slowdown targets, 8.8 |
| slowdown_i | input | NCORES·SD_W | Estimated per-core slowdowns, 8.8 |
| weight_i | input | NCORES·WT_W | Per-core priority weights, 4.4 |
| intf_cnt_i | input | NCORES·NCORES·IC_W | Interference matrix, victim-major |
| eval_strobe_o | output | 1 | One-cycle pulse marking fresh levels |
| level_o | output | NCORES·LVL_W | Per-core allowance level |
| miss_limit_o | output | NCORES·OUT_W | Per-core outstanding-miss limit |
| inj_gap_o | output | NCORES·LVL_W | Per-core idle cycles between requests |

## Verification
The bench goes after four kinds of corner case.

- **Ties.** It drives slowdowns and interference counts that tie. A selector that compared with ≥ would pick the higher index and move the wrong lane.
- **Threshold equality.** It sets the ratio and max targets exactly at the threshold. A design that used ≥ would throttle when it should hold.
- **Saturation.** It repeats one unfair pattern past both ends of the level range. A counter that wraps would jump from 0 to 7.
- **Weights and modes.** It checks that weights reorder the slowest core and that the frozen mode holds against wildly unfair inputs. It then runs a long pseudo-random sweep against an arithmetic model in every mode.

// File: rtl/fst_pkg.sv
package fst_pkg;

   typedef enum logic [1:0] {
      FST_RATIO   = 2'd0,
      FST_MAXSD   = 2'd1,
      FST_PERCORE = 2'd2,
      FST_HOLD    = 2'd3
   } fst_mode_e;

   // Outstanding-miss allowance for a level: linear low end, x1.5/x2 steps above.
   function automatic int unsigned fst_limit(input int unsigned lvl);
      if (lvl < 4) return lvl + 1;
      return (2 + (lvl & 1)) << (lvl >> 1);
   endfunction

endpackage

// File: rtl/fst_wscale.sv
module fst_wscale #(
   parameter int SD_W    = 16,
   parameter int WT_W    = 8,
   parameter int WT_FRAC = 4,
   localparam int OW     = SD_W + WT_W - WT_FRAC
) (
   input  logic [SD_W-1:0] sd_i,
   input  logic [WT_W-1:0] wt_i,
   output logic [OW-1:0]   wsd_o
);
   localparam int PW = SD_W + WT_W;
   logic [PW-1:0] prod;

   always_comb begin
      prod  = PW'(sd_i) * PW'(wt_i);
      wsd_o = prod[PW-1:WT_FRAC];
   end
endmodule

// File: rtl/fst_argsel.sv
module fst_argsel #(
   parameter int N        = 4,
   parameter int W        = 16,
   parameter bit PICK_MIN = 1'b0,
   localparam int IDX_W   = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N*W-1:0] val_i,
   input  logic [N-1:0]   excl_i,
   output logic [IDX_W-1:0] idx_o
);
   logic [N-1:0] better;
   logic [W-1:0] best_v [N+1];
   logic [IDX_W-1:0] best_i [N+1];
   logic         found  [N+1];

   assign best_v[0] = '0;
   assign best_i[0] = '0;
   assign found[0]  = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_scan
      logic [W-1:0] v;
      assign v = val_i[i*W +: W];
      if (PICK_MIN) begin : g_min
         assign better[i] = !excl_i[i] && (!found[i] || (v < best_v[i]));
      end else begin : g_max
         assign better[i] = !excl_i[i] && (!found[i] || (v > best_v[i]));
      end
      assign best_v[i+1] = better[i] ? v : best_v[i];
      assign best_i[i+1] = better[i] ? IDX_W'(i) : best_i[i];
      assign found[i+1]  = found[i] | better[i];
   end

   assign idx_o = best_i[N];
endmodule

// File: rtl/fst_lane.sv
module fst_lane
   import fst_pkg::*;
#(
   parameter int LVL_W = 3,
   parameter int OUT_W = 5,
   localparam int LVL_MAX = (1 << LVL_W) - 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             up_i,
   input  logic             dn_i,
   output logic [LVL_W-1:0] level_o,
   output logic [OUT_W-1:0] limit_o,
   output logic [LVL_W-1:0] gap_o
);
   logic [LVL_W-1:0] level_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         level_q <= LVL_W'(LVL_MAX);
      end else if (up_i && (level_q != LVL_W'(LVL_MAX))) begin
         level_q <= level_q + 1'b1;
      end else if (dn_i && (level_q != '0)) begin
         level_q <= level_q - 1'b1;
      end
   end

   always_comb begin
      level_o = level_q;
      limit_o = OUT_W'(fst_limit(int'(level_q)));
      gap_o   = LVL_W'(LVL_MAX) - level_q;
   end
endmodule

// File: rtl/src_throttle_ctl.sv
module src_throttle_ctl
   import fst_pkg::*;
#(
   parameter int NCORES   = 4,
   parameter int SD_W     = 16,
   parameter int SD_FRAC  = 8,
   parameter int WT_W     = 8,
   parameter int WT_FRAC  = 4,
   parameter int IC_W     = 8,
   parameter int LVL_W    = 3,
   parameter int OUT_W    = 5,
   parameter int INTERVAL = 1024
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [1:0]                  mode_i,
   input  logic [SD_W-1:0]             sys_tgt_i,
   input  logic [NCORES*SD_W-1:0]      core_tgt_i,
   input  logic [NCORES*SD_W-1:0]      slowdown_i,
   input  logic [NCORES*WT_W-1:0]      weight_i,
   input  logic [NCORES*NCORES*IC_W-1:0] intf_cnt_i,
   output logic                        eval_strobe_o,
   output logic [NCORES*LVL_W-1:0]     level_o,
   output logic [NCORES*OUT_W-1:0]     miss_limit_o,
   output logic [NCORES*LVL_W-1:0]     inj_gap_o
);
   localparam int IDX_W   = $clog2(NCORES);
   localparam int WSD_W   = SD_W + WT_W - WT_FRAC;
   localparam int CMP_W   = SD_W + WSD_W + SD_FRAC;
   localparam int ROW_W   = NCORES * IC_W;
   localparam int CNT_W   = $clog2(INTERVAL);
   localparam int LVL_MAX = (1 << LVL_W) - 1;

   // Elaboration-time parameter checks
   if (NCORES < 2) begin : g_bad_cores
      $error("src_throttle_ctl: NCORES must be at least 2");
   end
   if (INTERVAL < 2) begin : g_bad_interval
      $error("src_throttle_ctl: INTERVAL must be at least 2");
   end
   if (WT_FRAC > WT_W) begin : g_bad_wt
      $error("src_throttle_ctl: WT_FRAC exceeds WT_W");
   end
   if (SD_FRAC >= SD_W) begin : g_bad_sd
      $error("src_throttle_ctl: SD_FRAC must be below SD_W");
   end
   if (fst_limit(LVL_MAX) >= (1 << OUT_W)) begin : g_bad_out
      $error("src_throttle_ctl: OUT_W too narrow for the top level's miss limit");
   end

   // Interval timer
   logic [CNT_W-1:0] cnt_q;
   logic             eval_now;
   logic             strobe_q;

   assign eval_now = (cnt_q == CNT_W'(INTERVAL - 1));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         strobe_q <= 1'b0;
      end else begin
         cnt_q    <= eval_now ? '0 : cnt_q + 1'b1;
         strobe_q <= eval_now;
      end
   end
   assign eval_strobe_o = strobe_q;

   // Weighted slowdowns
   logic [NCORES*WSD_W-1:0] wsd_flat;
   logic [NCORES-1:0]       over_own;

   for (genvar c = 0; c < NCORES; c++) begin : g_core
      logic [WSD_W-1:0] w;
      fst_wscale #(.SD_W(SD_W), .WT_W(WT_W), .WT_FRAC(WT_FRAC)) u_scale (
         .sd_i  (slowdown_i[c*SD_W +: SD_W]),
         .wt_i  (weight_i[c*WT_W +: WT_W]),
         .wsd_o (w)
      );
      assign wsd_flat[c*WSD_W +: WSD_W] = w;
      assign over_own[c] = (w > WSD_W'(core_tgt_i[c*SD_W +: SD_W]));
   end

   // Slowest and least-slowed cores
   logic [IDX_W-1:0] slow_idx, fast_idx, intf_idx;

   fst_argsel #(.N(NCORES), .W(WSD_W), .PICK_MIN(1'b0)) u_slowest (
      .val_i (wsd_flat),
      .excl_i('0),
      .idx_o (slow_idx)
   );

   fst_argsel #(.N(NCORES), .W(WSD_W), .PICK_MIN(1'b1)) u_fastest (
      .val_i (wsd_flat),
      .excl_i('0),
      .idx_o (fast_idx)
   );

   logic [WSD_W-1:0]  max_w, min_w;
   logic [ROW_W-1:0]  victim_row;
   logic [NCORES-1:0] self_mask;

   always_comb begin
      max_w      = '0;
      min_w      = '0;
      victim_row = '0;
      self_mask  = '0;
      for (int c = 0; c < NCORES; c++) begin
         if (slow_idx == IDX_W'(c)) begin
            max_w        = wsd_flat[c*WSD_W +: WSD_W];
            victim_row   = intf_cnt_i[c*ROW_W +: ROW_W];
            self_mask[c] = 1'b1;
         end
         if (fast_idx == IDX_W'(c)) begin
            min_w = wsd_flat[c*WSD_W +: WSD_W];
         end
      end
   end

   // Core that hurt the slowest one most
   fst_argsel #(.N(NCORES), .W(IC_W), .PICK_MIN(1'b0)) u_interferer (
      .val_i (victim_row),
      .excl_i(self_mask),
      .idx_o (intf_idx)
   );

   // Fairness test
   logic [CMP_W-1:0] ratio_lhs, ratio_rhs;
   logic             unfair;

   always_comb begin
      ratio_lhs = CMP_W'(max_w) << SD_FRAC;
      ratio_rhs = CMP_W'(sys_tgt_i) * CMP_W'(min_w);
      unique case (fst_mode_e'(mode_i))
         FST_RATIO:   unfair = (ratio_lhs > ratio_rhs);
         FST_MAXSD:   unfair = (max_w > WSD_W'(sys_tgt_i));
         FST_PERCORE: unfair = |over_own;
         default:     unfair = 1'b0;
      endcase
   end

   // Per-core throttle state
   for (genvar c = 0; c < NCORES; c++) begin : g_lane
      logic up, dn;
      assign up = eval_now && unfair && (slow_idx == IDX_W'(c));
      assign dn = eval_now && unfair && (intf_idx == IDX_W'(c));
      fst_lane #(.LVL_W(LVL_W), .OUT_W(OUT_W)) u_lane (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .up_i   (up),
         .dn_i   (dn),
         .level_o(level_o[c*LVL_W +: LVL_W]),
         .limit_o(miss_limit_o[c*OUT_W +: OUT_W]),
         .gap_o  (inj_gap_o[c*LVL_W +: LVL_W])
      );
   end
endmodule

// File: rtl/fst_throttle_chk.sv
module fst_throttle_chk #(
   parameter int NCORES = 4,
   parameter int LVL_W  = 3,
   localparam int IDX_W = $clog2(NCORES)
) (
   input logic                    clk_i,
   input logic                    rst_ni,
   input logic                    eval_i,
   input logic                    unfair_i,
   input logic [1:0]              mode_i,
   input logic [IDX_W-1:0]        slow_i,
   input logic [IDX_W-1:0]        intf_i,
   input logic [NCORES*LVL_W-1:0] level_i
);
   logic [NCORES*LVL_W-1:0] prev_q;
   logic [NCORES-1:0]       moved;

   always_ff @(posedge clk_i) prev_q <= level_i;

   for (genvar c = 0; c < NCORES; c++) begin : g_lane_chk
      assign moved[c] = (level_i[c*LVL_W +: LVL_W] != prev_q[c*LVL_W +: LVL_W]);

      assert_step_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (level_i[c*LVL_W +: LVL_W] != $past(level_i[c*LVL_W +: LVL_W])) |->
            ((level_i[c*LVL_W +: LVL_W] == $past(level_i[c*LVL_W +: LVL_W]) + 1'b1) ||
             (level_i[c*LVL_W +: LVL_W] + 1'b1 == $past(level_i[c*LVL_W +: LVL_W]))));

      assert_rise_only_slowest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (level_i[c*LVL_W +: LVL_W] > $past(level_i[c*LVL_W +: LVL_W])) |->
            ($past(eval_i) && $past(slow_i) == IDX_W'(c)));

      assert_fall_only_interferer_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (level_i[c*LVL_W +: LVL_W] < $past(level_i[c*LVL_W +: LVL_W])) |->
            ($past(eval_i) && $past(intf_i) == IDX_W'(c)));
   end

   assert_at_most_two_moves_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(moved) <= 2);

   assert_quiet_between_evals_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !eval_i |=> $stable(level_i));

   assert_fair_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && !unfair_i) |=> $stable(level_i));

   assert_frozen_mode_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && mode_i == 2'd3) |=> $stable(level_i));

   assert_victim_not_culprit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eval_i |-> (slow_i != intf_i));
endmodule

bind src_throttle_ctl fst_throttle_chk #(.NCORES(NCORES), .LVL_W(LVL_W)) u_fst_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .eval_i  (eval_now),
   .unfair_i(unfair),
   .mode_i  (mode_i),
   .slow_i  (slow_idx),
   .intf_i  (intf_idx),
   .level_i (level_o)
);

// File: tb/tb_src_throttle_ctl.sv
module tb_src_throttle_ctl;
   localparam int CLK_PERIOD = 10;
   localparam int N    = 4;
   localparam int SDW  = 16;
   localparam int WTW  = 8;
   localparam int ICW  = 8;
   localparam int LW   = 3;
   localparam int OW   = 5;
   localparam int IVL  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode;
   logic [SDW-1:0] stgt;
   logic [N*SDW-1:0] ctgt_v, sd_v;
   logic [N*WTW-1:0] wt_v;
   logic [N*N*ICW-1:0] ic_v;
   logic strobe;
   logic [N*LW-1:0] lvl_v, gap_v;
   logic [N*OW-1:0] lim_v;

   always #(CLK_PERIOD/2) clk = ~clk;

   src_throttle_ctl #(
      .NCORES(N), .SD_W(SDW), .SD_FRAC(8), .WT_W(WTW), .WT_FRAC(4),
      .IC_W(ICW), .LVL_W(LW), .OUT_W(OW), .INTERVAL(IVL)
   ) dut (
      .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sys_tgt_i(stgt),
      .core_tgt_i(ctgt_v), .slowdown_i(sd_v), .weight_i(wt_v),
      .intf_cnt_i(ic_v), .eval_strobe_o(strobe), .level_o(lvl_v),
      .miss_limit_o(lim_v), .inj_gap_o(gap_v)
   );

   int n_chk = 0;
   int n_bad = 0;
   int sd_a[N], wt_a[N], ct_a[N], ic_a[N][N], exp_lvl[N];
   int st_a, md_a;
   logic [31:0] rs = 32'h1234_5677;

   function automatic int exp_limit(input int l);
      if (l < 4) return l + 1;
      return (2 + l % 2) * (1 << (l / 2));
   endfunction

   function automatic int rnd();
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 17);
      rs = rs ^ (rs << 5);
      return int'(rs & 32'h7fff_ffff);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic base();
      for (int i = 0; i < N; i++) begin
         sd_a[i] = 'h100; wt_a[i] = 16; ct_a[i] = 'hFFFF;
         for (int j = 0; j < N; j++) ic_a[i][j] = 0;
      end
      st_a = 'h100; md_a = 3;
   endtask

   task automatic apply();
      mode = 2'(md_a);
      stgt = SDW'(st_a);
      for (int i = 0; i < N; i++) begin
         sd_v[i*SDW +: SDW]   = SDW'(sd_a[i]);
         wt_v[i*WTW +: WTW]   = WTW'(wt_a[i]);
         ctgt_v[i*SDW +: SDW] = SDW'(ct_a[i]);
         for (int j = 0; j < N; j++) ic_v[(i*N+j)*ICW +: ICW] = ICW'(ic_a[i][j]);
      end
   endtask

   // Arithmetic model of one evaluation
   task automatic model();
      longint w[N];
      longint mx, mn;
      int slow, intf, best;
      bit trig;
      for (int i = 0; i < N; i++) w[i] = (longint'(sd_a[i]) * wt_a[i]) >> 4;
      slow = 0; mx = w[0]; mn = w[0];
      for (int i = 1; i < N; i++) begin
         if (w[i] > mx) begin mx = w[i]; slow = i; end
         if (w[i] < mn) mn = w[i];
      end
      intf = -1; best = 0;
      for (int j = 0; j < N; j++) begin
         if (j != slow && (intf < 0 || ic_a[slow][j] > best)) begin
            intf = j; best = ic_a[slow][j];
         end
      end
      case (md_a)
         0: trig = (mx * 256) > (longint'(st_a) * mn);
         1: trig = mx > st_a;
         2: begin
            trig = 1'b0;
            for (int i = 0; i < N; i++) if (w[i] > ct_a[i]) trig = 1'b1;
         end
         default: trig = 1'b0;
      endcase
      if (trig) begin
         if (exp_lvl[slow] < 7) exp_lvl[slow]++;
         if (exp_lvl[intf] > 0) exp_lvl[intf]--;
      end
   endtask

   task automatic wait_strobe(input bit timed);
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!strobe && n < 100);
      if (timed) chk(n == IVL, "R2 interval length", n, IVL);
   endtask

   task automatic check_lanes(input string tag);
      for (int i = 0; i < N; i++) begin
         chk(int'(lvl_v[i*LW +: LW]) == exp_lvl[i], {tag, " level"}, int'(lvl_v[i*LW +: LW]), exp_lvl[i]);
         chk(int'(lim_v[i*OW +: OW]) == exp_limit(exp_lvl[i]), "R11 miss limit",
             int'(lim_v[i*OW +: OW]), exp_limit(exp_lvl[i]));
         chk(int'(gap_v[i*LW +: LW]) == 7 - exp_lvl[i], "R11 injection gap",
             int'(gap_v[i*LW +: LW]), 7 - exp_lvl[i]);
      end
   endtask

   task automatic step(input string tag);
      apply();
      model();
      wait_strobe(1'b1);
      check_lanes(tag);
   endtask

   function automatic string mode_tag(input int m);
      case (m)
         0: return "R7 ratio mode";
         1: return "R8 max mode";
         2: return "R9 per-core mode";
         default: return "R10 frozen mode";
      endcase
   endfunction

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < N; i++) exp_lvl[i] = 7;
      base();
      apply();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_lanes("R1 reset");
      model();
      wait_strobe(1'b0);
      check_lanes("R10 frozen after reset");

      // R3 tie on slowdown goes to core 0; R4 tie on count goes to core 1
      base();
      for (int i = 0; i < N; i++) sd_a[i] = 'h200;
      ic_a[0][1] = 5; ic_a[0][3] = 5; md_a = 1;
      step("R3 R4 tie to lowest index");

      // R3 weight reorders: core 2 slowest only through its weight
      base();
      sd_a[0] = 'h200; sd_a[1] = 'h200; sd_a[2] = 'h180; wt_a[2] = 32;
      ic_a[2][0] = 3; ic_a[2][3] = 9; md_a = 0; st_a = 'h200;
      step("R3 weighted selection");

      // R7 exact equality holds, one below triggers
      base();
      sd_a[1] = 'h300; ic_a[1][2] = 4; md_a = 0; st_a = 'h300;
      step("R7 equality holds");
      st_a = 'h2FF;
      step("R7 just over target");

      // R8 equality holds
      base();
      sd_a[3] = 'h180; md_a = 1; st_a = 'h180; ic_a[3][1] = 2;
      step("R8 equality holds");

      // R9 one core over its own target
      base();
      ct_a[2] = 'h0FF; ic_a[0][2] = 6; md_a = 2;
      step("R9 own target exceeded");

      // R10 frozen despite extreme unfairness
      base();
      sd_a[0] = 'hF000; ic_a[0][1] = 200; md_a = 3; st_a = 'h100;
      step("R10 frozen");

      // R5 saturation at both ends
      base();
      sd_a[3] = 'h400; ic_a[3][0] = 7; md_a = 1;
      for (int k = 0; k < 9; k++) step("R5 saturate low");
      base();
      sd_a[0] = 'h400; ic_a[0][3] = 7; md_a = 1;
      for (int k = 0; k < 9; k++) step("R5 saturate high");

      // R6 fair interval with large targets
      base();
      md_a = 1; st_a = 'hFFFF; sd_a[2] = 'h800;
      step("R6 fair holds");

      // Pseudo-random sweep across all modes
      for (int k = 0; k < 160; k++) begin
         md_a = k % 4;
         for (int i = 0; i < N; i++) begin
            sd_a[i] = 128 + (rnd() % 4) * 96;
            wt_a[i] = 8 + (rnd() % 4) * 8;
            ct_a[i] = 'h100 + (rnd() % 8) * 'h80;
            for (int j = 0; j < N; j++) ic_a[i][j] = rnd() % 8;
         end
         st_a = (md_a == 0) ? 'h100 + (rnd() % 4) * 'h100 : 'h100 + (rnd() % 8) * 'h60;
         step(mode_tag(md_a));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule